// File: doc/BRIEF.md
# Atomic Read-Modify-Write Shared Memory

This block is a small word-addressed memory that several requesters share. Each requester port can issue a plain load or a plain store. It can also issue two indivisible operations: a test-and-set, used for spin locks, and a compare-and-swap, used for lock-free updates. A separate request line asks for an ordering fence. The unit accepts one request per cycle from all ports together and picks among competing ports in rotating order. Each accepted request returns one result word on the shared response bus, tagged by a per-port response strobe.

Loads, stores and fences finish in one cycle. An atomic operation takes two cycles: a read cycle, then a conditional-write cycle. No port is accepted during the second cycle, so no access from another port can fall between the read and the write. A fence from a port is accepted only when every earlier request from that port has delivered its response. Any request made after the fence therefore starts after those earlier operations have finished.

Top module: `amu_atomic_mem`

## Requirements
- R1: After reset every memory word reads as 0, no response strobe is high, and no ready is high while no request is valid.
- R2: A store writes its data word to the addressed location and returns 0. A later load of that location from any port returns the stored word.
- R3: Test-and-set (opcode 2'b10) returns the old word. It writes 1 to the location only when the old word was 0; otherwise the location is unchanged.
- R4: Compare-and-swap (opcode 2'b11) returns the old word. It writes the new-value word only when the old word equals the expected word; otherwise the location is unchanged.
- R5: In the cycle after an atomic request is accepted, no port is accepted. A load that follows the atomic sees the atomic's write.
- R6: At most one port's ready is high in any cycle.
- R7: While several ports hold valid requests, they are accepted in rotating order. The first to be served is the port after the one accepted last, counting up and wrapping to port 0.
- R8: A fence (fence line high; the opcode is ignored) from a port is not accepted while that port still has a response outstanding. Its response carries 0.
- R9: Loads, stores and fences respond in the cycle after acceptance. Atomic operations respond two cycles after acceptance.
- R10: A store of 0 to a lock word releases it. The next test-and-set on that word returns 0.
- R11: A port's ready is high only while that port's request valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | PORTS | Request present, one bit per port |
| req_op | input | 2*PORTS | Opcode per port: 00 load, 01 store, 10 test-and-set, 11 compare-and-swap |
| req_fence | input | PORTS | Fence request per port (overrides opcode) |
| req_addr | input | AW*PORTS | Word address per port |
| req_wdata | input | DW*PORTS | Store data or swap new value per port |
| req_cmp | input | DW*PORTS | Expected word for compare-and-swap per port |
| req_ready | output | PORTS | Request accepted this cycle, one bit per port |
| rsp_valid | output | PORTS | Response strobe per port |
| rsp_data | output | DW | Result word of the current response |

## Verification
The bench builds the block with three ports, eight words and 16-bit data. A port count that is not a power of two makes the rotating pointer wrap from port 2 back to port 0, a step a power-of-two count would perform for free. The small depth lets directed tests reuse a few lock and counter words across test-and-set, compare-and-swap and store sequences. Three ports are also enough to put an atomic from one port against a load from another in the same cycle, and to hold a fence behind an outstanding atomic response.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAS   = 2'b10,
    OP_CAS   = 2'b11
  } amu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RMW  = 1'b1
  } amu_state_e;
endpackage

// File: rtl/amu_word_store.sv
module amu_word_store #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];

  assign rdata = word_q[addr];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = we && (addr == AW'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (hit) begin
        word_q[w] <= wdata;
      end
    end
  end
endmodule

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
  parameter int PORTS = 4,
  localparam int IW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PORTS-1:0] req,
  output logic [PORTS-1:0] gnt,
  output logic [IW-1:0]    gnt_idx,
  output logic             gnt_valid
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt       = '0;
    gnt_idx   = '0;
    gnt_valid = 1'b0;
    for (int k = 0; k < PORTS; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % PORTS;
      if (en && !gnt_valid && req[idx]) begin
        gnt[idx]  = 1'b1;
        gnt_idx   = IW'(idx);
        gnt_valid = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_valid) begin
      ptr_d = (int'(gnt_idx) == PORTS - 1) ? '0 : gnt_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_valid) begin
      ptr_q <= ptr_d;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R6
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0)); // R11
endmodule

// File: rtl/amu_rmw_engine.sv
module amu_rmw_engine
  import amu_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int IW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_valid,
  input  logic [PORTS-1:0] gnt,
  input  logic [IW-1:0]    gnt_idx,
  input  logic [1:0]       gnt_op,
  input  logic             gnt_fence,
  input  logic [AW-1:0]    gnt_addr,
  input  logic [DW-1:0]    gnt_wdata,
  input  logic [DW-1:0]    gnt_cmp,
  output logic             accept_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic [PORTS-1:0] rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  amu_state_e       state_q, state_d;
  logic [IW-1:0]    lat_idx_q, lat_idx_d;
  amu_op_e          lat_op_q, lat_op_d;
  logic [AW-1:0]    lat_addr_q, lat_addr_d;
  logic [DW-1:0]    lat_wdata_q, lat_wdata_d;
  logic [DW-1:0]    lat_cmp_q, lat_cmp_d;
  logic [PORTS-1:0] rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]    rsp_data_q, rsp_data_d;
  logic             latch_en;
  logic             is_atomic;

  assign accept_en = (state_q == ST_IDLE);
  assign is_atomic = !gnt_fence && gnt_op[1];
  assign latch_en  = gnt_valid && is_atomic && (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    lat_idx_d   = lat_idx_q;
    lat_op_d    = lat_op_q;
    lat_addr_d  = lat_addr_q;
    lat_wdata_d = lat_wdata_q;
    lat_cmp_d   = lat_cmp_q;
    rsp_valid_d = '0;
    rsp_data_d  = rsp_data_q;
    mem_addr    = gnt_addr;
    mem_we      = 1'b0;
    mem_wdata   = gnt_wdata;
    if (state_q == ST_IDLE) begin
      if (gnt_valid) begin
        if (gnt_fence) begin
          rsp_valid_d = gnt;
          rsp_data_d  = '0;
        end else if (is_atomic) begin
          state_d     = ST_RMW;
          lat_idx_d   = gnt_idx;
          lat_op_d    = amu_op_e'(gnt_op);
          lat_addr_d  = gnt_addr;
          lat_wdata_d = gnt_wdata;
          lat_cmp_d   = gnt_cmp;
        end else if (amu_op_e'(gnt_op) == OP_STORE) begin
          mem_we      = 1'b1;
          rsp_valid_d = gnt;
          rsp_data_d  = '0;
        end else begin
          rsp_valid_d = gnt;
          rsp_data_d  = mem_rdata;
        end
      end
    end else begin
      mem_addr = lat_addr_q;
      if (lat_op_q == OP_TAS) begin
        mem_we    = (mem_rdata == '0);
        mem_wdata = DW'(1);
      end else begin
        mem_we    = (mem_rdata == lat_cmp_q);
        mem_wdata = lat_wdata_q;
      end
      rsp_valid_d            = '0;
      rsp_valid_d[lat_idx_q] = 1'b1;
      rsp_data_d             = mem_rdata;
      state_d                = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_idx_q   <= '0;
      lat_op_q    <= OP_LOAD;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      lat_cmp_q   <= '0;
    end else if (latch_en) begin
      lat_idx_q   <= lat_idx_d;
      lat_op_q    <= lat_op_d;
      lat_addr_q  <= lat_addr_d;
      lat_wdata_q <= lat_wdata_d;
      lat_cmp_q   <= lat_cmp_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_RMW_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RMW) |-> !gnt_valid); // R5
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid_q)); // R9
  AST_TAS_KEEPS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RMW && lat_op_q == OP_TAS && mem_rdata != '0) |=>
      (rsp_data_q != '0)); // R3
endmodule

// File: rtl/amu_atomic_mem.sv
module amu_atomic_mem
  import amu_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORTS-1:0]    req_valid,
  input  logic [2*PORTS-1:0]  req_op,
  input  logic [PORTS-1:0]    req_fence,
  input  logic [AW*PORTS-1:0] req_addr,
  input  logic [DW*PORTS-1:0] req_wdata,
  input  logic [DW*PORTS-1:0] req_cmp,
  output logic [PORTS-1:0]    req_ready,
  output logic [PORTS-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_data
);
  localparam int IW = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic          rst_meta_q, rst_sync_q;
  logic          rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ns = rst_sync_q;

  logic [PORTS-1:0] pending_q, pending_d;
  logic [PORTS-1:0] eligible;
  logic [PORTS-1:0] gnt;
  logic [IW-1:0]    gnt_idx;
  logic             gnt_valid;
  logic             accept_en;
  logic [1:0]       sel_op;
  logic             sel_fence;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic [DW-1:0]    sel_cmp;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_rdata;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata;

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    assign eligible[i]  = req_valid[i] && (!req_fence[i] || !pending_q[i]);
    assign pending_d[i] = gnt[i] ? 1'b1 : (rsp_valid[i] ? 1'b0 : pending_q[i]);

    AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_ns)
      (req_ready[i] && req_fence[i]) |-> !rsp_valid[i]); // R8
    AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_ns)
      (req_ready[i] && (req_fence[i] || !req_op[2*i+1])) |=> rsp_valid[i]); // R9
    AST_ATOMIC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ns)
      (req_ready[i] && !req_fence[i] && req_op[2*i+1]) |=>
        (req_ready == '0 && !rsp_valid[i])); // R5
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pending_q <= '0;
    end else begin
      pending_q <= pending_d;
    end
  end

  amu_rr_arb #(.PORTS(PORTS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_ns),
    .en        (accept_en),
    .req       (eligible),
    .gnt       (gnt),
    .gnt_idx   (gnt_idx),
    .gnt_valid (gnt_valid)
  );

  always_comb begin
    sel_op    = '0;
    sel_fence = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    sel_cmp   = '0;
    for (int i = 0; i < PORTS; i++) begin
      if (gnt[i]) begin
        sel_op    = req_op[2*i +: 2];
        sel_fence = req_fence[i];
        sel_addr  = req_addr[AW*i +: AW];
        sel_wdata = req_wdata[DW*i +: DW];
        sel_cmp   = req_cmp[DW*i +: DW];
      end
    end
  end

  amu_rmw_engine #(.PORTS(PORTS), .AW(AW), .DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_ns),
    .gnt_valid (gnt_valid),
    .gnt       (gnt),
    .gnt_idx   (gnt_idx),
    .gnt_op    (sel_op),
    .gnt_fence (sel_fence),
    .gnt_addr  (sel_addr),
    .gnt_wdata (sel_wdata),
    .gnt_cmp   (sel_cmp),
    .accept_en (accept_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  amu_word_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_ns),
    .addr  (mem_addr),
    .rdata (mem_rdata),
    .we    (mem_we),
    .wdata (mem_wdata)
  );

  assign req_ready = gnt;
endmodule

// File: tb/amu_atomic_mem_tb_top.sv
module amu_atomic_mem_tb_top;
  localparam int P  = 3;
  localparam int AW = 3;
  localparam int DW = 16;

  logic            clk;
  logic            rst_n;
  logic [P-1:0]    req_valid;
  logic [2*P-1:0]  req_op;
  logic [P-1:0]    req_fence;
  logic [AW*P-1:0] req_addr;
  logic [DW*P-1:0] req_wdata;
  logic [DW*P-1:0] req_cmp;
  logic [P-1:0]    req_ready;
  logic [P-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_data;

  int checks = 0;
  int errors = 0;
  int last_gnt = P - 1;
  bit done = 0;

  amu_atomic_mem #(.PORTS(P), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_fence(req_fence), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cmp(req_cmp), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int p, input logic [1:0] op, input logic f,
                         input int a, input int wd, input int cm);
    req_valid[p]         = 1'b1;
    req_op[2*p +: 2]     = op;
    req_fence[p]         = f;
    req_addr[AW*p +: AW] = AW'(a);
    req_wdata[DW*p +: DW] = DW'(wd);
    req_cmp[DW*p +: DW]   = DW'(cm);
  endtask

  task automatic clr_req(input int p);
    req_valid[p] = 1'b0;
    req_fence[p] = 1'b0;
  endtask

  task automatic do_op(input int p, input logic [1:0] op, input logic f,
                       input int a, input int wd, input int cm,
                       input int exp_lat, input string tag, output int rd);
    int lat;
    @(negedge clk);
    set_req(p, op, f, a, wd, cm);
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    last_gnt = p;
    @(negedge clk);
    clr_req(p);
    lat = 1;
    while (!rsp_valid[p] && lat < 10) begin @(negedge clk); lat++; end
    rd = int'(rsp_data);
    check({tag, " latency"}, lat, exp_lat);
  endtask

  task automatic t_reset();
    int rd;
    check("R1 ready idle", int'(req_ready), 0);
    check("R1 rsp idle", int'(rsp_valid), 0);
    do_op(1, 2'b00, 0, 5, 0, 0, 1, "R1 load", rd);
    check("R1 reset word", rd, 0);
  endtask

  task automatic t_store_load();
    int rd;
    do_op(0, 2'b01, 0, 2, 'h1234, 0, 1, "R9 store", rd);
    check("R2 store returns 0", rd, 0);
    do_op(0, 2'b00, 0, 2, 0, 0, 1, "R9 load", rd);
    check("R2 load same port", rd, 'h1234);
    do_op(2, 2'b01, 0, 7, 'hbeef, 0, 1, "R2 store p2", rd);
    do_op(0, 2'b00, 0, 7, 0, 0, 1, "R2 load p0", rd);
    check("R2 cross port", rd, 'hbeef);
  endtask

  task automatic t_tas();
    int rd;
    do_op(0, 2'b10, 0, 3, 0, 0, 2, "R9 tas", rd);
    check("R3 tas free", rd, 0);
    do_op(1, 2'b10, 0, 3, 0, 0, 2, "R3 tas 2", rd);
    check("R3 tas held", rd, 1);
    do_op(2, 2'b01, 0, 3, 'h55, 0, 1, "R3 store", rd);
    do_op(2, 2'b10, 0, 3, 0, 0, 2, "R3 tas 3", rd);
    check("R3 tas old nonzero", rd, 'h55);
    do_op(1, 2'b00, 0, 3, 0, 0, 1, "R3 load", rd);
    check("R3 nonzero kept", rd, 'h55);
    do_op(0, 2'b01, 0, 3, 0, 0, 1, "R10 release", rd);
    do_op(1, 2'b10, 0, 3, 0, 0, 2, "R10 tas", rd);
    check("R10 reacquire", rd, 0);
  endtask

  task automatic t_cas();
    int rd;
    do_op(0, 2'b01, 0, 4, 10, 0, 1, "R4 seed", rd);
    do_op(1, 2'b11, 0, 4, 20, 9, 2, "R9 cas", rd);
    check("R4 cas miss old", rd, 10);
    do_op(2, 2'b00, 0, 4, 0, 0, 1, "R4 load", rd);
    check("R4 miss unchanged", rd, 10);
    do_op(1, 2'b11, 0, 4, 20, 10, 2, "R4 cas hit", rd);
    check("R4 cas hit old", rd, 10);
    do_op(0, 2'b00, 0, 4, 0, 0, 1, "R4 load 2", rd);
    check("R4 hit written", rd, 20);
  endtask

  task automatic t_rr();
    int order [P];
    @(negedge clk);
    for (int p = 0; p < P; p++) set_req(p, 2'b00, 0, p, 0, 0);
    for (int k = 0; k < P; k++) begin
      #1;
      order[k] = -1;
      for (int p = 0; p < P; p++) if (req_ready[p]) order[k] = p;
      @(negedge clk);
      if (order[k] >= 0) clr_req(order[k]);
    end
    for (int k = 0; k < P; k++) check("R7 rotation", order[k], (last_gnt + 1 + k) % P);
    last_gnt = order[P-1];
    @(negedge clk);
  endtask

  task automatic t_atomic_block();
    int rd;
    if (last_gnt != P - 1) do_op(P - 1, 2'b00, 0, 0, 0, 0, 1, "R5 align", rd);
    @(negedge clk);
    set_req(0, 2'b10, 0, 6, 0, 0);
    set_req(1, 2'b00, 0, 6, 0, 0);
    #1;
    check("R6 single grant", int'(req_ready), 1);
    @(negedge clk);
    clr_req(0);
    #1;
    check("R5 no grant in rmw", int'(req_ready), 0);
    @(negedge clk);
    #1;
    check("R5 tas rsp", int'(rsp_valid), 1);
    check("R5 tas old", int'(rsp_data), 0);
    check("R5 load next", int'(req_ready), 2);
    @(negedge clk);
    clr_req(1);
    check("R5 load rsp", int'(rsp_valid), 2);
    check("R5 load sees tas", int'(rsp_data), 1);
    last_gnt = 1;
  endtask

  task automatic t_fence();
    @(negedge clk);
    set_req(1, 2'b11, 0, 4, 30, 20);
    #1;
    check("R8 cas granted", int'(req_ready), 2);
    @(negedge clk);
    set_req(1, 2'b00, 1, 0, 0, 0);
    #1;
    check("R8 fence waits rmw", int'(req_ready), 0);
    @(negedge clk);
    #1;
    check("R8 cas rsp", int'(rsp_valid), 2);
    check("R8 cas old", int'(rsp_data), 20);
    check("R8 fence waits pending", int'(req_ready), 0);
    @(negedge clk);
    #1;
    check("R8 fence granted", int'(req_ready), 2);
    @(negedge clk);
    clr_req(1);
    check("R8 fence rsp", int'(rsp_valid), 2);
    check("R8 fence data", int'(rsp_data), 0);
    last_gnt = 1;
  endtask

  initial begin
    req_valid = '0; req_op = '0; req_fence = '0;
    req_addr = '0; req_wdata = '0; req_cmp = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_store_load();
    t_tas();
    t_cas();
    t_rr();
    t_atomic_block();
    t_fence();
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule